// File: doc/BRIEF.md
# Remote Terminal Command Decoder

This block sits between a remote terminal's serial front end and its DMA engine. Each cycle in which `cmdValid` is high, it takes one 16-bit interrogation word from the bus controller. A 3-bit mode field in bits 14:12 of that word selects the operation. The decoder then does any of the following that the mode calls for:

- it updates a small set of configuration registers (the transfer bus choice, a programmed address with an enable, and a 7-bit user control output);
- it pulses load, proceed, reset or error-clear strobes towards the DMA engine;
- it schedules a response word.

The response word appears exactly two cycles after the interrogation. Its content is picked from the DMA engine's live address, length or data inputs, or from a status word. The status word is built from the bi-level inputs, the service-request input, the DMA error input and the current bus choice. Because the selection is applied to live inputs during the response cycle, the response shows the DMA state as it is just before transmission. For example, it shows a start address that was loaded by the same command one cycle earlier.

Top module: `rt_cmd_decoder`

## Requirements
- R1: Only modes 0, 1, 3, 4 and 7 with bit 15 clear are valid. Modes 2, 5 and 6, mode 0 with sub-code 3 in bits 1:0, and any word with bit 15 set cause no strobe, no configuration change and no response.
- R2: The cycle after an accepted valid interrogation carries its strobes. Its response (`rspValid` high for one cycle) appears two cycles after the interrogation cycle. `rspWord` is zero whenever `rspValid` is low.
- R3: Mode 0 uses bits 1:0 to pick the response: 0 returns `dmaAddr`, 1 returns `dmaLen`, 2 returns the status word. The status word is `{5'b0, busSel[2:0], dmaErr, svcReq, bilevel[5:0]}`.
- R4: A valid mode 0 read pulses `dmaErrClr` for one cycle.
- R5: In mode 1, bits 11:10 = 0 select the bus code in bits 2:0. The codes are: 0 input on interrogation bus, 1 input on response bus, 2 output on response bus, 3 block-transfer input, 4 block-transfer output. Codes 5 to 7 leave `busSel` unchanged. `busSel` resets to 0.
- R6: In mode 1, bits 11:10 = 1 set the programmed address from bits 4:0. All ones clears `progAddrEn` and keeps the address. All zeros changes nothing. Any other value loads the address and sets `progAddrEn`. Both reset to 0.
- R7: In mode 1, bits 11:10 = 2 load `userCtl` from bits 6:0, except that the value 127 leaves it unchanged. `userCtl` resets to 0.
- R8: In mode 1, bits 11:10 = 3 pulse `dmaReset`. Every mode 1 word responds with the status word. Mode 1 settings hold until a later mode 1 word changes them, and the new value is visible in that word's status response.
- R9: Mode 3 pulses `dmaLoadAddr` with `dmaLoadValue` equal to bits 11:0, and responds with `dmaAddr`.
- R10: Mode 4 pulses `dmaLoadLen` with `dmaLoadValue` equal to bits 11:0, and responds with `dmaLen`.
- R11: Mode 7 pulses `dmaProceed`. Its response depends on the bus code in force when the strobe is issued: code 0 returns `dmaLen`, code 1 gives no response, code 2 returns `dmaData`, codes 3 and 4 return the status word.
- R12: Response words are taken from the DMA and status inputs during the response cycle itself, not when the interrogation arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Interrogation word present this cycle |
| cmdWord | input | 16 | Interrogation word |
| bilevel | input | 6 | User bi-level status inputs |
| svcReq | input | 1 | User service-request input |
| dmaAddr | input | 16 | Current DMA address |
| dmaLen | input | 16 | Remaining DMA block length |
| dmaData | input | 16 | Data word fetched by the DMA engine |
| dmaErr | input | 1 | DMA error indication |
| busSel | output | 3 | Selected transfer bus code |
| progAddr | output | 5 | Programmed address |
| progAddrEn | output | 1 | Programmed address enabled |
| userCtl | output | 7 | User control outputs |
| dmaLoadAddr | output | 1 | Load start address strobe |
| dmaLoadLen | output | 1 | Load block length strobe |
| dmaLoadValue | output | 12 | Value for the load strobes |
| dmaProceed | output | 1 | Proceed strobe |
| dmaReset | output | 1 | DMA reset strobe |
| dmaErrClr | output | 1 | DMA error clear strobe |
| rspValid | output | 1 | Response word valid |
| rspWord | output | 16 | Response word |

## Verification
The assertions check properties that hold on every cycle:

- a response only ever follows an interrogation two cycles earlier;
- no strobe appears without an interrogation the cycle before;
- at most one DMA strobe is active at a time;
- the response word is quiet when no response is due;
- `busSel` never holds an unused code, `userCtl` never holds 127, and an enabled programmed address is never all ones.

The bench scenarios are needed for the rest. Only they can show that each mode picks the right response source, and that proceed responses follow the bus choice. They also show that a "no change" field really keeps the earlier setting, and that a response reflects a DMA load made one cycle before it.

// File: rtl/rtcd_pkg.sv
package rtcd_pkg;
  localparam int WORD_W   = 16;
  localparam int ARG_W    = 12;
  localparam int MODE_LSB = 12;
  localparam int BUS_W    = 3;
  localparam int BIL_W    = 6;

  localparam logic [2:0] MD_READ    = 3'd0;
  localparam logic [2:0] MD_INSTR   = 3'd1;
  localparam logic [2:0] MD_LDADDR  = 3'd3;
  localparam logic [2:0] MD_LDLEN   = 3'd4;
  localparam logic [2:0] MD_PROCEED = 3'd7;

  localparam logic [1:0] INS_BUS = 2'd0;
  localparam logic [1:0] INS_PA  = 2'd1;
  localparam logic [1:0] INS_UCC = 2'd2;
  localparam logic [1:0] INS_RST = 2'd3;

  localparam logic [BUS_W-1:0] BUS_IIN   = 3'd0;
  localparam logic [BUS_W-1:0] BUS_RIN   = 3'd1;
  localparam logic [BUS_W-1:0] BUS_ROUT  = 3'd2;
  localparam logic [BUS_W-1:0] BUS_BTIN  = 3'd3;
  localparam logic [BUS_W-1:0] BUS_BTOUT = 3'd4;

  typedef enum logic [2:0] {
    RK_NONE, RK_ADDR, RK_LEN, RK_STAT, RK_DATA
  } rspKind_t;

  typedef struct packed {
    logic             ldAddr;
    logic             ldLen;
    logic             proceed;
    logic             dmaRst;
    logic             errClr;
    logic             setBus;
    logic             setPa;
    logic             setUcc;
    logic [ARG_W-1:0] arg;
  } ctrlStrb_t;
endpackage

// File: rtl/rtcd_ctrl.sv
module rtcd_ctrl
  import rtcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [BUS_W-1:0]  busSel,
  output ctrlStrb_t         strb,
  output rspKind_t          rspKind
);
  logic              s1Valid;
  logic [WORD_W-1:0] s1Word;
  rspKind_t          kindNext;
  logic [2:0]        mode;
  logic [1:0]        sub;

  // stage 1: hold the accepted interrogation for one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Word  <= '0;
    end else begin
      s1Valid <= cmdValid & ~cmdWord[WORD_W-1];
      s1Word  <= cmdWord;
    end
  end

  assign mode = s1Word[MODE_LSB +: 3];
  assign sub  = s1Word[ARG_W-1 -: 2];

  always_comb begin
    strb     = '0;
    strb.arg = s1Word[ARG_W-1:0];
    kindNext = RK_NONE;
    if (s1Valid) begin
      case (mode)
        MD_READ: begin
          case (s1Word[1:0])
            2'd0:    kindNext = RK_ADDR;
            2'd1:    kindNext = RK_LEN;
            2'd2:    kindNext = RK_STAT;
            default: kindNext = RK_NONE;
          endcase
          strb.errClr = (s1Word[1:0] != 2'd3);
        end
        MD_INSTR: begin
          kindNext    = RK_STAT;
          strb.setBus = (sub == INS_BUS);
          strb.setPa  = (sub == INS_PA);
          strb.setUcc = (sub == INS_UCC);
          strb.dmaRst = (sub == INS_RST);
        end
        MD_LDADDR: begin
          kindNext    = RK_ADDR;
          strb.ldAddr = 1'b1;
        end
        MD_LDLEN: begin
          kindNext   = RK_LEN;
          strb.ldLen = 1'b1;
        end
        MD_PROCEED: begin
          strb.proceed = 1'b1;
          case (busSel)
            BUS_IIN:             kindNext = RK_LEN;
            BUS_ROUT:            kindNext = RK_DATA;
            BUS_BTIN, BUS_BTOUT: kindNext = RK_STAT;
            default:             kindNext = RK_NONE;
          endcase
        end
        default: kindNext = RK_NONE;
      endcase
    end
  end

  // stage 2: response slot
  always_ff @(posedge clk) begin
    if (!rstN) rspKind <= RK_NONE;
    else       rspKind <= kindNext;
  end
endmodule

// File: rtl/rtcd_datapath.sv
module rtcd_datapath
  import rtcd_pkg::*;
#(
  parameter int PA_W = 5,
  parameter int UC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  rspKind_t          rspKind,
  input  logic [BIL_W-1:0]  bilevel,
  input  logic              svcReq,
  input  logic [WORD_W-1:0] dmaAddr,
  input  logic [WORD_W-1:0] dmaLen,
  input  logic [WORD_W-1:0] dmaData,
  input  logic              dmaErr,
  output logic [BUS_W-1:0]  busSel,
  output logic [PA_W-1:0]   progAddr,
  output logic              progAddrEn,
  output logic [UC_W-1:0]   userCtl,
  output logic              dmaLoadAddr,
  output logic              dmaLoadLen,
  output logic [ARG_W-1:0]  dmaLoadValue,
  output logic              dmaProceed,
  output logic              dmaReset,
  output logic              dmaErrClr,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspWord
);
  localparam int STAT_PAD = WORD_W - BUS_W - 2 - BIL_W;

  logic [PA_W-1:0]  paArg;
  logic [UC_W-1:0]  ucArg;
  logic [BUS_W-1:0] busArg;
  logic [WORD_W-1:0] statWord;

  assign paArg  = strb.arg[PA_W-1:0];
  assign ucArg  = strb.arg[UC_W-1:0];
  assign busArg = strb.arg[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busSel     <= BUS_IIN;
      progAddr   <= '0;
      progAddrEn <= 1'b0;
      userCtl    <= '0;
    end else begin
      if (strb.setBus && busArg <= BUS_BTOUT) busSel <= busArg;
      if (strb.setPa) begin
        if (&paArg) progAddrEn <= 1'b0;
        else if (|paArg) begin
          progAddr   <= paArg;
          progAddrEn <= 1'b1;
        end
      end
      if (strb.setUcc && !(&ucArg)) userCtl <= ucArg;
    end
  end

  assign dmaLoadAddr  = strb.ldAddr;
  assign dmaLoadLen   = strb.ldLen;
  assign dmaLoadValue = strb.arg;
  assign dmaProceed   = strb.proceed;
  assign dmaReset     = strb.dmaRst;
  assign dmaErrClr    = strb.errClr;

  assign statWord = {{STAT_PAD{1'b0}}, busSel, dmaErr, svcReq, bilevel};

  // live selection: data reflects DMA state in the response cycle
  always_comb begin
    rspValid = (rspKind != RK_NONE);
    case (rspKind)
      RK_ADDR: rspWord = dmaAddr;
      RK_LEN:  rspWord = dmaLen;
      RK_STAT: rspWord = statWord;
      RK_DATA: rspWord = dmaData;
      default: rspWord = '0;
    endcase
  end
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
  import rtcd_pkg::*;
#(
  parameter int PA_W = 5,
  parameter int UC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic [BIL_W-1:0]  bilevel,
  input  logic              svcReq,
  input  logic [WORD_W-1:0] dmaAddr,
  input  logic [WORD_W-1:0] dmaLen,
  input  logic [WORD_W-1:0] dmaData,
  input  logic              dmaErr,
  output logic [BUS_W-1:0]  busSel,
  output logic [PA_W-1:0]   progAddr,
  output logic              progAddrEn,
  output logic [UC_W-1:0]   userCtl,
  output logic              dmaLoadAddr,
  output logic              dmaLoadLen,
  output logic [ARG_W-1:0]  dmaLoadValue,
  output logic              dmaProceed,
  output logic              dmaReset,
  output logic              dmaErrClr,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspWord
);
  ctrlStrb_t strb;
  rspKind_t  rspKind;

  rtcd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .busSel(busSel), .strb(strb), .rspKind(rspKind)
  );

  rtcd_datapath #(.PA_W(PA_W), .UC_W(UC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rspKind(rspKind),
    .bilevel(bilevel), .svcReq(svcReq), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaData(dmaData), .dmaErr(dmaErr), .busSel(busSel), .progAddr(progAddr),
    .progAddrEn(progAddrEn), .userCtl(userCtl), .dmaLoadAddr(dmaLoadAddr),
    .dmaLoadLen(dmaLoadLen), .dmaLoadValue(dmaLoadValue),
    .dmaProceed(dmaProceed), .dmaReset(dmaReset), .dmaErrClr(dmaErrClr),
    .rspValid(rspValid), .rspWord(rspWord)
  );
endmodule

// File: rtl/rt_cmd_decoder_chk.sv
module rt_cmd_decoder_chk #(
  parameter int PA_W = 5,
  parameter int UC_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [2:0]      busSel,
  input logic [PA_W-1:0] progAddr,
  input logic            progAddrEn,
  input logic [UC_W-1:0] userCtl,
  input logic            dmaLoadAddr,
  input logic            dmaLoadLen,
  input logic            dmaProceed,
  input logic            dmaReset,
  input logic            dmaErrClr,
  input logic            rspValid,
  input logic [15:0]     rspWord
);
  // R2
  rsp_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(cmdValid, 2));

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspWord == 16'h0);

  // R1
  strobe_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaLoadAddr | dmaLoadLen | dmaProceed | dmaReset | dmaErrClr) |-> $past(cmdValid));

  // R11
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaLoadAddr, dmaLoadLen, dmaProceed, dmaReset, dmaErrClr}));

  // R5
  bus_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel <= 3'd4);

  // R6
  pa_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    progAddrEn |-> progAddr != '1);

  // R7
  ucc_never_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    userCtl != '1);
endmodule

bind rt_cmd_decoder rt_cmd_decoder_chk #(.PA_W(PA_W), .UC_W(UC_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busSel(busSel),
  .progAddr(progAddr), .progAddrEn(progAddrEn), .userCtl(userCtl),
  .dmaLoadAddr(dmaLoadAddr), .dmaLoadLen(dmaLoadLen), .dmaProceed(dmaProceed),
  .dmaReset(dmaReset), .dmaErrClr(dmaErrClr), .rspValid(rspValid),
  .rspWord(rspWord)
);

// File: tb/test_rt_cmd_decoder.sv
module test_rt_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdWord = 16'h0;
  logic [5:0]  bilevel = 6'h0;
  logic        svcReq = 1'b0;
  logic [15:0] dAddr, dLen, dData;
  logic        dErr;
  logic [2:0]  busSel;
  logic [4:0]  progAddr;
  logic        progAddrEn;
  logic [6:0]  userCtl;
  logic        ldA, ldL, proc, dRst, eClr, rspValid;
  logic [11:0] ldVal;
  logic [15:0] rspWord;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rt_cmd_decoder i_rt_cmd_decoder (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .bilevel(bilevel), .svcReq(svcReq), .dmaAddr(dAddr), .dmaLen(dLen),
    .dmaData(dData), .dmaErr(dErr), .busSel(busSel), .progAddr(progAddr),
    .progAddrEn(progAddrEn), .userCtl(userCtl), .dmaLoadAddr(ldA),
    .dmaLoadLen(ldL), .dmaLoadValue(ldVal), .dmaProceed(proc),
    .dmaReset(dRst), .dmaErrClr(eClr), .rspValid(rspValid), .rspWord(rspWord)
  );

  // behavioural DMA engine in the environment
  assign dData = dAddr * 16'd3 + 16'd7;
  always @(posedge clk) begin
    if (!rstN || dRst) begin
      dAddr <= 16'h0; dLen <= 16'h0; dErr <= 1'b0;
    end else begin
      if (ldA) dAddr <= {4'h0, ldVal};
      if (ldL) dLen <= {4'h0, ldVal};
      if (proc) begin
        if (dLen == 16'h0) dErr <= 1'b1;
        else begin dAddr <= dAddr + 16'd1; dLen <= dLen - 16'd1; end
      end
      if (eClr) dErr <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit          curV, p1V, p2V;
  logic [15:0] curW, p1W, p2W;
  int          p1K, p2K;
  logic [2:0]  mBus;
  logic [4:0]  mPa;
  bit          mPaEn;
  logic [6:0]  mUcc;

  function automatic bit isValid(bit v, logic [15:0] w);
    return v && !w[15];
  endfunction

  // 0 none, 1 address, 2 length, 3 status, 4 data
  function automatic int kindOf(bit v, logic [15:0] w, logic [2:0] bus);
    if (!isValid(v, w)) return 0;
    case (w[14:12])
      3'd0: return (w[1:0] == 2'd3) ? 0 : int'(w[1:0]) + 1;
      3'd1: return 3;
      3'd3: return 1;
      3'd4: return 2;
      3'd7: return (bus == 3'd0) ? 2 : (bus == 3'd1) ? 0 : (bus == 3'd2) ? 4 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(bit v, logic [15:0] w);
    if (!isValid(v, w)) return "R1";
    case (w[14:12])
      3'd0: return "R4";
      3'd1: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd7: return "R11";
      default: return "R1";
    endcase
  endfunction

  function automatic string rspTag(logic [15:0] w);
    case (w[14:12])
      3'd0: return "R3 R12";
      3'd1: return "R8 R12";
      3'd3: return "R9 R12";
      3'd4: return "R10 R12";
      default: return "R11 R12";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      curV = 0; p1V = 0; p2V = 0; p1K = 0; p2K = 0;
      mBus = 3'd0; mPa = 5'd0; mPaEn = 0; mUcc = 7'd0;
    end else begin
      logic [4:0] expS;
      logic [15:0] expW;
      p2V = p1V; p2W = p1W; p2K = p1K;
      if (isValid(p2V, p2W) && p2W[14:12] == 3'd1) begin
        case (p2W[11:10])
          2'd0: if (p2W[2:0] <= 3'd4) mBus = p2W[2:0];
          2'd1: if (p2W[4:0] == 5'h1F) mPaEn = 0;
                else if (p2W[4:0] != 5'h0) begin mPa = p2W[4:0]; mPaEn = 1; end
          2'd2: if (p2W[6:0] != 7'h7F) mUcc = p2W[6:0];
          default: ;
        endcase
      end
      p1V = curV; p1W = curW; p1K = kindOf(p1V, p1W, mBus);

      expS = 5'b0;
      if (isValid(p1V, p1W)) begin
        expS[4] = (p1W[14:12] == 3'd3);
        expS[3] = (p1W[14:12] == 3'd4);
        expS[2] = (p1W[14:12] == 3'd7);
        expS[1] = (p1W[14:12] == 3'd1) && (p1W[11:10] == 2'd3);
        expS[0] = (p1W[14:12] == 3'd0) && (p1W[1:0] != 2'd3);
      end
      check({ldA, ldL, proc, dRst, eClr} == expS, tagOf(p1V, p1W), "strobes",
            {27'b0, ldA, ldL, proc, dRst, eClr}, {27'b0, expS});
      if (expS[4] || expS[3])
        check(ldVal == p1W[11:0], expS[4] ? "R9" : "R10", "load value",
              {20'b0, ldVal}, {20'b0, p1W[11:0]});
      check(busSel == mBus, "R5", "busSel", {29'b0, busSel}, {29'b0, mBus});
      check(progAddrEn == mPaEn && (!mPaEn || progAddr == mPa), "R6", "progAddr",
            {26'b0, progAddrEn, progAddr}, {26'b0, mPaEn, mPa});
      check(userCtl == mUcc, "R7", "userCtl", {25'b0, userCtl}, {25'b0, mUcc});
      check(rspValid == (p2K != 0), "R2", "rspValid",
            {31'b0, rspValid}, {31'b0, p2K != 0});
      case (p2K)
        1: expW = dAddr;
        2: expW = dLen;
        3: expW = {5'b0, mBus, dErr, svcReq, bilevel};
        4: expW = dData;
        default: expW = 16'h0;
      endcase
      check(rspWord == expW, (p2K == 0) ? "R2" : rspTag(p2W), "rspWord",
            {16'b0, rspWord}, {16'b0, expW});
      curV = cmdValid; curW = cmdWord;
    end
  end

  task automatic drive(input logic [15:0] w);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdWord = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmdValid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, R5 R6 R7 R2
    check(busSel == 3'd0 && !progAddrEn && userCtl == 7'd0, "R5", "reset config",
          {25'b0, userCtl}, 32'h0);
    check(!rspValid && rspWord == 16'h0 && {ldA, ldL, proc, dRst, eClr} == 5'b0,
          "R2", "reset outputs", {31'b0, rspValid}, 32'h0);
    @(posedge clk); #1 rstN = 1'b1;
    idle(2);
    bilevel = 6'h2A; svcReq = 1'b1;
    drive(16'h0002); idle(3);              // R3 status read
    drive(16'h7000); idle(3);              // R11 proceed with zero length -> error
    drive(16'h1002); idle(3);              // R5 bus = output on response bus, R8 status
    drive(16'h3123); drive(16'h4003);      // R9 R10 back to back
    drive(16'h7000); drive(16'h7000); drive(16'h7000); drive(16'h7000);  // R11 data, last errors
    idle(3);
    drive(16'h1005); idle(2);              // R5 unused code ignored
    drive(16'h1007); idle(2);
    drive(16'h1000); drive(16'h4002); drive(16'h7000); idle(3);  // R11 length on bus 0
    drive(16'h1001); drive(16'h7000); idle(3);                   // R11 no response
    drive(16'h1003); drive(16'h7000); idle(2);                   // R11 status
    drive(16'h1004); drive(16'h7000); idle(3);
    bilevel = 6'h15; svcReq = 1'b0;
    drive(16'h140A); idle(2);              // R6 load
    drive(16'h1400); idle(2);              // R6 zero no change
    drive(16'h141F); idle(2);              // R6 disable
    drive(16'h1405); idle(2);
    drive(16'h1855); idle(2);              // R7 load
    drive(16'h187F); idle(2);              // R7 127 ignored
    drive(16'h1800); idle(2);
    drive(16'h1C00); idle(3);              // R8 DMA reset
    drive(16'h2000); drive(16'h5FFF); drive(16'h6ABC); drive(16'h0003);  // R1 invalid
    drive(16'h8000); drive(16'hF123); idle(4);                           // R1 bit 15 set
    drive(16'h3ABC); drive(16'h0000); drive(16'h0001); idle(3);          // R12 R3
    drive(16'h4005); drive(16'h0001); drive(16'h0002); idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule